// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block joins two processors, called side A and side B, through a pair of one-word-deep mailbox lanes per channel and a set of doorbells. Each side has four 32-bit outbound data registers. A word written into outbound register n on one side appears in inbound register n on the other side. A per-channel fill flag tracks the word. The sender sees that flag as "outbound empty" and the receiver sees it as "inbound full". Status bits and enable bits combine into one interrupt line per side, so either processor can wait for data, for room, or for a doorbell without polling.

Doorbells work as follows. A side sets a request bit in its own control word. The request reaches the far side as a sticky pending flag, and the far side acknowledges it by writing a one to that flag. A layout parameter chooses how the flags are arranged. The packed layout puts every flag into one status word and one control word, with channels in reversed bit order. The linear layout gives each kind of flag its own word, with channel n at bit n.

Each side has a plain register bus. The bus has a byte address, a write strobe, a read strobe, write data, and read data that is registered one cycle after the read strobe. The bus has no wait states.

Top module: `mu_dual_messaging`

## Requirements
- R1: After reset every enable and request bit is 0, every pending and inbound-full flag is 0, every outbound-empty flag is 1, and both interrupt lines are low.
- R2: A write to outbound register n (byte offset 0x00 + 4n) clears the writer's outbound-empty n and sets the far side's inbound-full n, both from the next cycle on.
- R3: A read of inbound register n (byte offset 0x10 + 4n) clears inbound-full n on the reader and sets outbound-empty n on the far side, both from the next cycle on.
- R4: Writing 1 to request bit n sets the far side's pending flag n one cycle after the request bit is latched. The request bit then reads back as 0.
- R5: A pending flag stays set when its bit is written with 0. It clears when its own side writes a 1 at its position in the status word.
- R6: Writes to the inbound-full and outbound-empty bits are ignored in both layouts.
- R7: A side's interrupt is high exactly when some flag and its matching enable are both 1 on that side. A set flag whose enable is 0 raises no interrupt.
- R8: The packed layout has the status word at 0x20 and the control word at 0x24. Channel n sits at these bits:
  - pending and doorbell enable: 31-n
  - inbound-full and inbound enable: 27-n
  - outbound-empty and outbound enable: 23-n
  - request: 19-n
- R9: The linear layout uses these words, with channel n at bit n of each:
  - 0x20: pending (write 1 to clear)
  - 0x24: inbound-full (read only)
  - 0x28: outbound-empty (read only)
  - 0x30: doorbell enable
  - 0x34: inbound enable
  - 0x38: outbound enable
  - 0x3C: request
- R10: Read data appears on the read-data port one cycle after the read strobe. A read of outbound register n returns the word last written there, and a read of inbound register n returns the word the far side last wrote to its outbound register n.
- R11: Both directions behave the same: B to A traffic follows R2 and R3 just as A to B traffic does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | ADDR_W | Side A byte address |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one cycle after the strobe |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | ADDR_W | Side B byte address |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one cycle after the strobe |
| b_irq | output | 1 | Side B interrupt |

## Verification
The assertions assume the following about the inputs:
- A side never asserts its write and read strobes in the same cycle.
- The address is stable whenever a strobe is high.

The bench drives at most one access per side per cycle, and it holds address and data steady from the falling edge through the sampling edge. A further assumption is that no side clears a pending flag in the same cycle the far side raises it. The stimulus always leaves at least one idle cycle between a request and the acknowledging write, so the race where the set wins never occurs.

// File: rtl/mu_pkg.sv
package mu_pkg;

  localparam int unsigned CH    = 4;
  localparam int unsigned REG_W = 32;

  typedef enum logic {
    LAYOUT_PACKED = 1'b0,
    LAYOUT_LINEAR = 1'b1
  } mu_layout_e;

  // byte offsets shared by both layouts
  localparam int unsigned OFS_TX0 = 'h00;
  localparam int unsigned OFS_RX0 = 'h10;

  // packed layout
  localparam int unsigned OFS_PK_STAT = 'h20;
  localparam int unsigned OFS_PK_CTRL = 'h24;
  localparam int unsigned PK_GP_BASE  = 28;
  localparam int unsigned PK_RX_BASE  = 24;
  localparam int unsigned PK_TX_BASE  = 20;
  localparam int unsigned PK_REQ_BASE = 16;

  // linear layout
  localparam int unsigned OFS_LN_PEND  = 'h20;
  localparam int unsigned OFS_LN_FULL  = 'h24;
  localparam int unsigned OFS_LN_EMPTY = 'h28;
  localparam int unsigned OFS_LN_GPEN  = 'h30;
  localparam int unsigned OFS_LN_RXEN  = 'h34;
  localparam int unsigned OFS_LN_TXEN  = 'h38;
  localparam int unsigned OFS_LN_REQ   = 'h3C;

  // channel n lands at bit base+CH-1-n (reversed order inside the field)
  function automatic logic [REG_W-1:0] pack_field(input logic [CH-1:0] v,
                                                  input int unsigned base);
    logic [REG_W-1:0] w;
    w = '0;
    for (int n = 0; n < CH; n++) w[base + CH - 1 - n] = v[n];
    return w;
  endfunction

  function automatic logic [CH-1:0] unpack_field(input logic [REG_W-1:0] w,
                                                 input int unsigned base);
    logic [CH-1:0] v;
    for (int n = 0; n < CH; n++) v[n] = w[base + CH - 1 - n];
    return v;
  endfunction

  function automatic logic [REG_W-1:0] widen(input logic [CH-1:0] v);
    return {{(REG_W - CH){1'b0}}, v};
  endfunction

endpackage

// File: rtl/mu_lane.sv
module mu_lane #(
  parameter int unsigned CH_N = 4,
  parameter int unsigned W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CH_N-1:0]          push,
  input  logic [W-1:0]             push_data,
  input  logic [CH_N-1:0]          pop,
  output logic [CH_N-1:0][W-1:0]   word_q,
  output logic [CH_N-1:0]          full_q
);

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
        full_q[g] <= 1'b0;
      end else begin
        if (push[g]) word_q[g] <= push_data;
        full_q[g] <= (full_q[g] & ~pop[g]) | push[g];
      end
    end

    p_push_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push[g] |=> full_q[g]);
    p_pop_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pop[g] && !push[g] |=> !full_q[g]);
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !push[g] && !pop[g] |=> $stable(full_q[g]));
  end

endmodule

// File: rtl/mu_side.sv
module mu_side
  import mu_pkg::*;
#(
  parameter mu_layout_e  LAYOUT = LAYOUT_PACKED,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [REG_W-1:0]            bus_wdata,
  output logic [REG_W-1:0]            bus_rdata,
  output logic                        irq,
  input  logic [CH-1:0][REG_W-1:0]    out_word,
  input  logic [CH-1:0]               out_full,
  input  logic [CH-1:0][REG_W-1:0]    in_word,
  input  logic [CH-1:0]               in_full,
  output logic [CH-1:0]               out_push,
  output logic [REG_W-1:0]            out_push_data,
  output logic [CH-1:0]               in_pop,
  output logic [CH-1:0]               req_o,
  input  logic [CH-1:0]               far_req_i
);

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic [CH-1:0] gp_en_q, rx_en_q, tx_en_q, req_q, pend_q;
  logic [CH-1:0] tx_hit, rx_hit, tx_empty;
  logic          gp_en_wr, rx_en_wr, tx_en_wr, req_wr;
  logic [CH-1:0] gp_en_d, rx_en_d, tx_en_d, req_d, pend_clr;
  logic [REG_W-1:0] reg_rd_val, rd_val;
  logic irq_gp, irq_rx, irq_tx;

  assign tx_empty = ~out_full;

  for (genvar g = 0; g < CH; g++) begin : g_dec
    assign tx_hit[g] = at(bus_addr, OFS_TX0 + 4 * g);
    assign rx_hit[g] = at(bus_addr, OFS_RX0 + 4 * g);
  end

  assign out_push      = bus_wr ? tx_hit : '0;
  assign in_pop        = bus_rd ? rx_hit : '0;
  assign out_push_data = bus_wdata;
  assign req_o         = req_q;

  if (LAYOUT == LAYOUT_PACKED) begin : g_packed
    logic ct_wr, st_wr;
    assign ct_wr    = bus_wr && at(bus_addr, OFS_PK_CTRL);
    assign st_wr    = bus_wr && at(bus_addr, OFS_PK_STAT);
    assign gp_en_wr = ct_wr;
    assign rx_en_wr = ct_wr;
    assign tx_en_wr = ct_wr;
    assign req_wr   = ct_wr;
    assign gp_en_d  = unpack_field(bus_wdata, PK_GP_BASE);
    assign rx_en_d  = unpack_field(bus_wdata, PK_RX_BASE);
    assign tx_en_d  = unpack_field(bus_wdata, PK_TX_BASE);
    assign req_d    = unpack_field(bus_wdata, PK_REQ_BASE);
    assign pend_clr = st_wr ? unpack_field(bus_wdata, PK_GP_BASE) : '0;

    always_comb begin
      if (at(bus_addr, OFS_PK_STAT))
        reg_rd_val = pack_field(pend_q, PK_GP_BASE) | pack_field(in_full, PK_RX_BASE)
                   | pack_field(tx_empty, PK_TX_BASE);
      else if (at(bus_addr, OFS_PK_CTRL))
        reg_rd_val = pack_field(gp_en_q, PK_GP_BASE) | pack_field(rx_en_q, PK_RX_BASE)
                   | pack_field(tx_en_q, PK_TX_BASE) | pack_field(req_q, PK_REQ_BASE);
      else
        reg_rd_val = '0;
    end
  end else begin : g_linear
    assign gp_en_wr = bus_wr && at(bus_addr, OFS_LN_GPEN);
    assign rx_en_wr = bus_wr && at(bus_addr, OFS_LN_RXEN);
    assign tx_en_wr = bus_wr && at(bus_addr, OFS_LN_TXEN);
    assign req_wr   = bus_wr && at(bus_addr, OFS_LN_REQ);
    assign gp_en_d  = bus_wdata[CH-1:0];
    assign rx_en_d  = bus_wdata[CH-1:0];
    assign tx_en_d  = bus_wdata[CH-1:0];
    assign req_d    = bus_wdata[CH-1:0];
    assign pend_clr = (bus_wr && at(bus_addr, OFS_LN_PEND)) ? bus_wdata[CH-1:0] : '0;

    always_comb begin
      if      (at(bus_addr, OFS_LN_PEND))  reg_rd_val = widen(pend_q);
      else if (at(bus_addr, OFS_LN_FULL))  reg_rd_val = widen(in_full);
      else if (at(bus_addr, OFS_LN_EMPTY)) reg_rd_val = widen(tx_empty);
      else if (at(bus_addr, OFS_LN_GPEN))  reg_rd_val = widen(gp_en_q);
      else if (at(bus_addr, OFS_LN_RXEN))  reg_rd_val = widen(rx_en_q);
      else if (at(bus_addr, OFS_LN_TXEN))  reg_rd_val = widen(tx_en_q);
      else if (at(bus_addr, OFS_LN_REQ))   reg_rd_val = widen(req_q);
      else                                 reg_rd_val = '0;
    end
  end

  always_comb begin
    rd_val = reg_rd_val;
    for (int n = 0; n < CH; n++) begin
      if (tx_hit[n]) rd_val = out_word[n];
      if (rx_hit[n]) rd_val = in_word[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_en_q   <= '0;
      rx_en_q   <= '0;
      tx_en_q   <= '0;
      req_q     <= '0;
      pend_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (gp_en_wr) gp_en_q <= gp_en_d;
      if (rx_en_wr) rx_en_q <= rx_en_d;
      if (tx_en_wr) tx_en_q <= tx_en_d;
      req_q  <= req_wr ? req_d : '0;
      pend_q <= (pend_q & ~pend_clr) | far_req_i;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  assign irq_gp = |(pend_q & gp_en_q);
  assign irq_rx = |(in_full & rx_en_q);
  assign irq_tx = |(tx_empty & tx_en_q);
  assign irq    = irq_gp | irq_rx | irq_tx;

  for (genvar g = 0; g < CH; g++) begin : g_chk
    p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] && !pend_clr[g] |=> pend_q[g]);
    p_pend_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr[g] && !far_req_i[g] |=> !pend_q[g]);
    p_pend_from_far_r4: assert property (@(posedge clk) disable iff (!rst_n)
      far_req_i[g] |=> pend_q[g]);
    p_req_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_q[g] && !req_wr |=> !req_q[g]);
  end

  p_irq_has_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((gp_en_q | rx_en_q | tx_en_q) != '0));
  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/mu_dual_messaging.sv
module mu_dual_messaging
  import mu_pkg::*;
#(
  parameter mu_layout_e  LAYOUT = LAYOUT_PACKED,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [REG_W-1:0]  a_wdata,
  output logic [REG_W-1:0]  a_rdata,
  output logic              a_irq,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [REG_W-1:0]  b_wdata,
  output logic [REG_W-1:0]  b_rdata,
  output logic              b_irq
);

  logic [CH-1:0][REG_W-1:0] ab_word, ba_word;
  logic [CH-1:0]            ab_full, ba_full;
  logic [CH-1:0]            a_push, b_push, a_pop, b_pop, a_req, b_req;
  logic [REG_W-1:0]         a_push_data, b_push_data;

  mu_lane #(.CH_N(CH), .W(REG_W)) u_lane_ab (
    .clk(clk), .rst_n(rst_n), .push(a_push), .push_data(a_push_data),
    .pop(b_pop), .word_q(ab_word), .full_q(ab_full));

  mu_lane #(.CH_N(CH), .W(REG_W)) u_lane_ba (
    .clk(clk), .rst_n(rst_n), .push(b_push), .push_data(b_push_data),
    .pop(a_pop), .word_q(ba_word), .full_q(ba_full));

  mu_side #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_side_a (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(a_addr), .bus_wr(a_wr), .bus_rd(a_rd), .bus_wdata(a_wdata),
    .bus_rdata(a_rdata), .irq(a_irq),
    .out_word(ab_word), .out_full(ab_full), .in_word(ba_word), .in_full(ba_full),
    .out_push(a_push), .out_push_data(a_push_data), .in_pop(a_pop),
    .req_o(a_req), .far_req_i(b_req));

  mu_side #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_side_b (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd), .bus_wdata(b_wdata),
    .bus_rdata(b_rdata), .irq(b_irq),
    .out_word(ba_word), .out_full(ba_full), .in_word(ab_word), .in_full(ab_full),
    .out_push(b_push), .out_push_data(b_push_data), .in_pop(b_pop),
    .req_o(b_req), .far_req_i(a_req));

  p_no_wr_rd_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_wr && a_rd) && !(b_wr && b_rd));

endmodule

// File: tb/mu_dual_messaging_tb_top.sv
module mu_dual_messaging_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [7:0]  addr  [2][2];
  logic        wr    [2][2];
  logic        rd    [2][2];
  logic [31:0] wdata [2][2];
  logic [31:0] rdata [2][2];
  logic        irq   [2][2];

  // index [dut][side]: dut 0 packed layout, dut 1 linear layout; side 0 = A, 1 = B
  mu_dual_messaging #(.LAYOUT(mu_pkg::LAYOUT_PACKED), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_addr(addr[0][0]), .a_wr(wr[0][0]), .a_rd(rd[0][0]), .a_wdata(wdata[0][0]),
    .a_rdata(rdata[0][0]), .a_irq(irq[0][0]),
    .b_addr(addr[0][1]), .b_wr(wr[0][1]), .b_rd(rd[0][1]), .b_wdata(wdata[0][1]),
    .b_rdata(rdata[0][1]), .b_irq(irq[0][1]));

  mu_dual_messaging #(.LAYOUT(mu_pkg::LAYOUT_LINEAR), .ADDR_W(8)) dut_lin_i (
    .clk(clk), .rst_n(rst_n),
    .a_addr(addr[1][0]), .a_wr(wr[1][0]), .a_rd(rd[1][0]), .a_wdata(wdata[1][0]),
    .a_rdata(rdata[1][0]), .a_irq(irq[1][0]),
    .b_addr(addr[1][1]), .b_wr(wr[1][1]), .b_rd(rd[1][1]), .b_wdata(wdata[1][1]),
    .b_rdata(rdata[1][1]), .b_irq(irq[1][1]));

  typedef struct {
    int          d;
    int          s;
    logic [31:0] exp;
    int          due;
  } item_t;

  item_t exp_q [$];
  string tag_q [$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  item_t mon_item;
  string mon_tag;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read results once their sampling edge has passed
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      mon_item = exp_q.pop_front();
      mon_tag  = tag_q.pop_front();
      compare(mon_tag, rdata[mon_item.d][mon_item.s], mon_item.exp);
    end
  end

  task automatic bus_write(input int d, input int s, input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    addr[d][s] = a; wdata[d][s] = v; wr[d][s] = 1'b1;
    @(posedge clk); #1;
    wr[d][s] = 1'b0;
  endtask

  task automatic bus_read(input int d, input int s, input logic [7:0] a,
                          input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr[d][s] = a; rd[d][s] = 1'b1;
    it.d = d; it.s = s; it.exp = e; it.due = cyc + 1;
    exp_q.push_back(it);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    rd[d][s] = 1'b0;
  endtask

  task automatic check_irq(input int d, input int s, input logic e, input string tag);
    @(negedge clk);
    compare(tag, {31'b0, irq[d][s]}, {31'b0, e});
  endtask

  initial begin
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++) begin
        addr[d][s] = '0; wr[d][s] = 1'b0; rd[d][s] = 1'b0; wdata[d][s] = '0;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // ---------------- packed layout (dut 0) ----------------
    // R1 reset state: outbound-empty bits 23..20 set, all else clear
    bus_read(0, 0, 8'h20, 32'h00F0_0000, "R1 A status");
    bus_read(0, 1, 8'h20, 32'h00F0_0000, "R1 B status");
    bus_read(0, 0, 8'h24, 32'h0000_0000, "R1 A control");
    bus_read(0, 1, 8'h24, 32'h0000_0000, "R1 B control");
    check_irq(0, 0, 1'b0, "R1 A irq");
    check_irq(0, 1, 1'b0, "R1 B irq");

    // R2 / R8: A -> B channel 0
    bus_write(0, 0, 8'h00, 32'hA5A5_0001);
    bus_read(0, 1, 8'h20, 32'h08F0_0000, "R2 R8 B inbound-full 0 at bit 27");
    bus_read(0, 0, 8'h20, 32'h0070_0000, "R2 R8 A outbound-empty 0 at bit 23 cleared");
    bus_read(0, 1, 8'h10, 32'hA5A5_0001, "R10 B inbound word 0");
    bus_read(0, 0, 8'h20, 32'h00F0_0000, "R3 A outbound-empty restored");
    bus_read(0, 1, 8'h20, 32'h00F0_0000, "R3 B inbound-full cleared");

    // R11: B -> A channel 3
    bus_write(0, 1, 8'h0C, 32'h0BAD_0003);
    bus_read(0, 0, 8'h20, 32'h01F0_0000, "R11 A inbound-full 3 at bit 24");
    bus_read(0, 1, 8'h20, 32'h00E0_0000, "R11 B outbound-empty 3 at bit 20 cleared");
    bus_read(0, 0, 8'h1C, 32'h0BAD_0003, "R11 A inbound word 3");
    bus_read(0, 1, 8'h20, 32'h00F0_0000, "R11 B outbound-empty 3 restored");

    // R4: A rings channel 1 (request at bit 18), pending at B bit 30
    bus_write(0, 0, 8'h24, 32'h0004_0000);
    @(posedge clk);
    bus_read(0, 1, 8'h20, 32'h40F0_0000, "R4 B pending 1");
    bus_read(0, 0, 8'h24, 32'h0000_0000, "R4 A request self-cleared");
    check_irq(0, 1, 1'b0, "R7 B irq off without enable");

    // R7: enable doorbell 1 on B
    bus_write(0, 1, 8'h24, 32'h4000_0000);
    check_irq(0, 1, 1'b1, "R7 B doorbell irq");
    bus_read(0, 1, 8'h24, 32'h4000_0000, "R8 B control enable readback");

    // R5 / R6
    bus_write(0, 1, 8'h20, 32'h0000_0000);
    bus_read(0, 1, 8'h20, 32'h40F0_0000, "R5 pending survives write of 0");
    bus_write(0, 1, 8'h20, 32'h0FFF_FFFF);
    bus_read(0, 1, 8'h20, 32'h40F0_0000, "R6 data-flag bits ignore writes");
    bus_write(0, 1, 8'h20, 32'h4000_0000);
    bus_read(0, 1, 8'h20, 32'h00F0_0000, "R5 pending cleared by write of 1");
    check_irq(0, 1, 1'b0, "R7 B irq drops after clear");

    // R7 inbound interrupt on B channel 0 (bit 27)
    bus_write(0, 1, 8'h24, 32'h0800_0000);
    bus_write(0, 0, 8'h00, 32'h1234_5678);
    check_irq(0, 1, 1'b1, "R7 B inbound irq");
    bus_read(0, 1, 8'h10, 32'h1234_5678, "R10 B inbound word 0 second");
    check_irq(0, 1, 1'b0, "R7 B inbound irq clears on read");

    // R7 outbound interrupt on A channel 0 (bit 23)
    bus_write(0, 0, 8'h24, 32'h0080_0000);
    check_irq(0, 0, 1'b1, "R7 A outbound irq while empty");
    bus_write(0, 0, 8'h00, 32'h5555_AAAA);
    check_irq(0, 0, 1'b0, "R7 A outbound irq drops when filled");
    bus_read(0, 0, 8'h00, 32'h5555_AAAA, "R10 A outbound word readback");
    bus_read(0, 1, 8'h10, 32'h5555_AAAA, "R10 B receives third word");
    check_irq(0, 0, 1'b1, "R3 R7 A outbound irq back after far read");

    // ---------------- linear layout (dut 1) ----------------
    bus_read(1, 0, 8'h28, 32'h0000_000F, "R1 R9 A outbound-empty word");
    bus_read(1, 0, 8'h24, 32'h0000_0000, "R1 R9 A inbound-full word");
    bus_read(1, 0, 8'h20, 32'h0000_0000, "R1 R9 A pending word");
    bus_read(1, 0, 8'h30, 32'h0000_0000, "R1 R9 A doorbell enable word");

    bus_write(1, 0, 8'h08, 32'hCAFE_0002);
    bus_read(1, 1, 8'h24, 32'h0000_0004, "R2 R9 B inbound-full 2");
    bus_read(1, 0, 8'h28, 32'h0000_000B, "R2 R9 A outbound-empty 2 cleared");
    bus_read(1, 1, 8'h18, 32'hCAFE_0002, "R10 R9 B inbound word 2");
    bus_read(1, 0, 8'h28, 32'h0000_000F, "R3 R9 A outbound-empty 2 restored");

    bus_write(1, 1, 8'h24, 32'h0000_000F);
    bus_read(1, 1, 8'h24, 32'h0000_0000, "R6 R9 inbound-full word ignores writes");

    bus_write(1, 0, 8'h30, 32'h0000_0008);
    bus_write(1, 1, 8'h3C, 32'h0000_0008);
    @(posedge clk);
    bus_read(1, 0, 8'h20, 32'h0000_0008, "R4 R9 A pending 3");
    check_irq(1, 0, 1'b1, "R7 R9 A doorbell irq");
    bus_read(1, 1, 8'h3C, 32'h0000_0000, "R4 R9 B request self-cleared");

    bus_write(1, 0, 8'h20, 32'h0000_0007);
    bus_read(1, 0, 8'h20, 32'h0000_0008, "R5 R9 pending kept on other bits");
    bus_write(1, 0, 8'h20, 32'h0000_0008);
    bus_read(1, 0, 8'h20, 32'h0000_0000, "R5 R9 pending cleared");
    check_irq(1, 0, 1'b0, "R7 R9 A irq drops");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule